// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a fixed-width 32-bit instruction stream goes next. Each cycle it may be handed the current 64-bit program counter, the instruction word found there, and the 64-bit value of the one register operand the instruction needs. That operand is the tested register for a conditional branch or the target register for a register-indirect jump. One cycle later it presents the next program counter, a taken flag, a link-register write request with its register index and value, and the prediction hint carried by the instruction.

Three kinds of control transfer are handled. Conditional branches test the low bit of the register or compare its signed value with zero. Unconditional branches always go to the PC-relative target and save a return address. Register-indirect jumps take their target from the register and also save a return address. Every other instruction word simply advances the PC by four. The architecture has no delay slots, so the instruction after a taken transfer is never executed: the next PC is the target and nothing else. Prediction, fetch and exceptions belong to other blocks. The hint bits are only decoded and passed on.

Top module: `nxpc_unit`

## Requirements
- R1: While rst_n is low, out_valid, taken and link_we are 0 and next_pc is zero.
- R2: The outputs are registered with one cycle of latency: out_valid equals in_valid of the previous cycle. For an instruction whose opcode (bits 31:26) is not a control opcode, next_pc is cur_pc + 4, taken is 0, link_we is 0 and hint is 2'b00.
- R3: A conditional branch (opcode 0x38 to 0x3F) that is taken gives next_pc = cur_pc + 4 + (sign-extended bits 20:0 shifted left by 2), computed modulo 2^64. If it is not taken, next_pc is cur_pc + 4. A conditional branch never requests a link write.
- R4: The low-bit tests are opcode 0x38 (taken when operand bit 0 is 0) and 0x3C (taken when operand bit 0 is 1).
- R5: The signed tests treat the operand as a signed 64-bit value. Opcode 0x39 is taken when it equals 0, 0x3D when it is not 0, 0x3A when it is below 0, 0x3B when it is at most 0, 0x3E when it is at least 0, and 0x3F when it is above 0.
- R6: Opcodes 0x30 and 0x34 are unconditional branches. taken is 1, next_pc is the PC-relative target of R3, link_reg is bits 25:21, link_val is cur_pc + 4, and hint is 2'b00 for 0x30 and 2'b01 for 0x34.
- R7: Opcode 0x1A is a register-indirect jump. taken is 1, next_pc is the operand with its two low bits forced to 0, link_reg is bits 25:21 and link_val is cur_pc + 4. The four hint variants in bits 15:14 behave identically, and those two bits appear on hint.
- R8: link_we is 1 for an unconditional branch or jump whose link register (bits 25:21) is not 31, and 0 when it is 31.
- R9: When in_valid is 0, the following cycle shows out_valid, taken and link_we at 0, whatever the instruction word holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| cur_pc | input | 64 | Word-aligned address of the instruction |
| insn_word | input | 32 | Instruction word |
| opnd_val | input | 64 | Tested register (branches) or target register (jumps) |
| out_valid | output | 1 | Result registered from a valid input |
| next_pc | output | 64 | Address of the next instruction to execute |
| taken | output | 1 | Control transfer redirected the PC |
| link_we | output | 1 | Write link_val into link_reg |
| link_reg | output | 5 | Register index receiving the return address |
| link_val | output | 64 | Return address (cur_pc + 4) |
| hint | output | 2 | Prediction hint passed through from the instruction |

## Verification
There is a single register stage, so any fault in decode, condition evaluation or target arithmetic shows on the ports exactly one cycle after the instruction is presented. A wrong condition polarity shows as a flipped taken flag together with a next_pc of cur_pc + 4 where the target was due, or the reverse. A sign-extension or shift fault shows only for displacements at the range ends or with the sign bit set, so those values are applied directly. A missing suppression for register 31 shows as a raised link_we.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
    localparam int XLEN   = 64;
    localparam int IW     = 32;
    localparam int OP_W   = 6;
    localparam int RIDX_W = 5;
    localparam int DISP_W = 21;
    localparam int HINT_W = 2;
    localparam int INSN_BYTES = IW / 8;

    localparam logic [RIDX_W-1:0] ZERO_REG = '1;

    localparam logic [OP_W-1:0] OP_JUMP  = 6'h1A;
    localparam logic [OP_W-1:0] OP_BRA   = 6'h30;
    localparam logic [OP_W-1:0] OP_BCALL = 6'h34;
    localparam logic [2:0]      COND_GRP = 3'b111;

    typedef enum logic [1:0] {
        CLS_SEQ    = 2'd0,
        CLS_COND   = 2'd1,
        CLS_UNCOND = 2'd2,
        CLS_JUMP   = 2'd3
    } ctl_cls_e;

    typedef struct packed {
        logic              vld;
        logic [XLEN-1:0]   npc;
        logic              tkn;
        logic              lwe;
        logic [RIDX_W-1:0] lreg;
        logic [XLEN-1:0]   lval;
        logic [HINT_W-1:0] hint;
    } nxpc_out_t;
endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
#(
    parameter int IWIDTH = IW
) (
    input  logic [IWIDTH-1:0]   insn,
    output ctl_cls_e            cls,
    output logic [2:0]          cond_code,
    output logic [RIDX_W-1:0]   ra_idx,
    output logic [DISP_W-1:0]   disp,
    output logic [HINT_W-1:0]   hint
);
    localparam int OP_LSB = IWIDTH - OP_W;
    localparam int RA_LSB = OP_LSB - RIDX_W;
    localparam int JH_LSB = RA_LSB - RIDX_W - HINT_W;

    logic [OP_W-1:0] opc;

    assign opc       = insn[IWIDTH-1:OP_LSB];
    assign ra_idx    = insn[RA_LSB +: RIDX_W];
    assign disp      = insn[DISP_W-1:0];
    assign cond_code = opc[2:0];

    always_comb begin
        cls  = CLS_SEQ;
        hint = '0;
        if (opc == OP_JUMP) begin
            cls  = CLS_JUMP;
            hint = insn[JH_LSB +: HINT_W];
        end else if (opc[OP_W-1 -: 3] == COND_GRP) begin
            cls = CLS_COND;
        end else if (opc == OP_BRA) begin
            cls = CLS_UNCOND;
        end else if (opc == OP_BCALL) begin
            cls  = CLS_UNCOND;
            hint = HINT_W'(1);
        end
    end
endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond #(
    parameter int WIDTH = 64
) (
    input  logic [2:0]       code,
    input  logic [WIDTH-1:0] opnd,
    output logic             pass
);
    logic is_zero;
    logic is_neg;
    logic base;

    assign is_zero = (opnd == '0);
    assign is_neg  = opnd[WIDTH-1];

    // code[1:0] selects a base test, code[2] selects its complement
    always_comb begin
        case (code[1:0])
            2'b00:   base = ~opnd[0];
            2'b01:   base = is_zero;
            2'b10:   base = is_neg;
            default: base = is_neg | is_zero;
        endcase
        pass = base ^ code[2];
    end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target #(
    parameter int WIDTH    = 64,
    parameter int DWIDTH   = 21,
    parameter int STEP     = 4,
    parameter int ALIGN_LG = 2
) (
    input  logic [WIDTH-1:0]  pc,
    input  logic [DWIDTH-1:0] disp,
    input  logic [WIDTH-1:0]  reg_tgt,
    output logic [WIDTH-1:0]  seq_pc,
    output logic [WIDTH-1:0]  rel_pc,
    output logic [WIDTH-1:0]  ind_pc
);
    localparam int EXT_W = WIDTH - DWIDTH - ALIGN_LG;

    logic [WIDTH-1:0] offs;

    assign seq_pc = pc + WIDTH'(STEP);

    generate
        if (EXT_W > 0) begin : g_ext
            assign offs = {{EXT_W{disp[DWIDTH-1]}}, disp, {ALIGN_LG{1'b0}}};
        end else begin : g_trunc
            assign offs = WIDTH'({disp, {ALIGN_LG{1'b0}}});
        end
    endgenerate

    assign rel_pc = seq_pc + offs;
    assign ind_pc = {reg_tgt[WIDTH-1:ALIGN_LG], {ALIGN_LG{1'b0}}};
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [IW-1:0]     insn_word,
    input  logic [XLEN-1:0]   opnd_val,
    output logic              out_valid,
    output logic [XLEN-1:0]   next_pc,
    output logic              taken,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_reg,
    output logic [XLEN-1:0]   link_val,
    output logic [HINT_W-1:0] hint
);
    ctl_cls_e          cls;
    logic [2:0]        cond_code;
    logic [RIDX_W-1:0] ra_idx;
    logic [DISP_W-1:0] disp;
    logic [HINT_W-1:0] hint_dec;
    logic              cond_pass;
    logic [XLEN-1:0]   seq_pc;
    logic [XLEN-1:0]   rel_pc;
    logic [XLEN-1:0]   ind_pc;

    nxpc_out_t st_d;
    nxpc_out_t st_q;

    nxpc_decode #(.IWIDTH(IW)) u_dec (
        .insn      (insn_word),
        .cls       (cls),
        .cond_code (cond_code),
        .ra_idx    (ra_idx),
        .disp      (disp),
        .hint      (hint_dec)
    );

    nxpc_cond #(.WIDTH(XLEN)) u_cond (
        .code (cond_code),
        .opnd (opnd_val),
        .pass (cond_pass)
    );

    nxpc_target #(
        .WIDTH    (XLEN),
        .DWIDTH   (DISP_W),
        .STEP     (INSN_BYTES),
        .ALIGN_LG ($clog2(INSN_BYTES))
    ) u_tgt (
        .pc      (cur_pc),
        .disp    (disp),
        .reg_tgt (opnd_val),
        .seq_pc  (seq_pc),
        .rel_pc  (rel_pc),
        .ind_pc  (ind_pc)
    );

    always_comb begin
        st_d      = '0;
        st_d.vld  = in_valid;
        st_d.npc  = seq_pc;
        st_d.lreg = ra_idx;
        st_d.lval = seq_pc;
        st_d.hint = hint_dec;
        case (cls)
            CLS_COND: begin
                st_d.tkn = in_valid & cond_pass;
                st_d.npc = cond_pass ? rel_pc : seq_pc;
            end
            CLS_UNCOND: begin
                st_d.tkn = in_valid;
                st_d.npc = rel_pc;
                st_d.lwe = in_valid & (ra_idx != ZERO_REG);
            end
            CLS_JUMP: begin
                st_d.tkn = in_valid;
                st_d.npc = ind_pc;
                st_d.lwe = in_valid & (ra_idx != ZERO_REG);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign next_pc   = st_q.npc;
    assign taken     = st_q.tkn;
    assign link_we   = st_q.lwe;
    assign link_reg  = st_q.lreg;
    assign link_val  = st_q.lval;
    assign hint      = st_q.hint;
endmodule

// File: rtl/nxpc_chk.sv
module nxpc_chk
    import nxpc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [XLEN-1:0]   cur_pc,
    input logic [IW-1:0]     insn_word,
    input logic              out_valid,
    input logic [XLEN-1:0]   next_pc,
    input logic              taken,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_reg,
    input logic [XLEN-1:0]   link_val
);
    logic [OP_W-1:0] opc;
    logic            is_ctl;

    assign opc    = insn_word[IW-1 -: OP_W];
    assign is_ctl = (opc == OP_JUMP) || (opc == OP_BRA) || (opc == OP_BCALL)
                    || (opc[OP_W-1 -: 3] == COND_GRP);

    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (!out_valid && !taken && !link_we && next_pc == '0);
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !taken && !link_we));

    p_seq_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_ctl) |=> (next_pc == $past(cur_pc) + XLEN'(INSN_BYTES) && !taken && !link_we));

    p_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_pc == $past(cur_pc) + XLEN'(INSN_BYTES)));

    p_link_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!link_we || link_val == $past(cur_pc) + XLEN'(INSN_BYTES)));

    p_no_zero_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_reg != ZERO_REG && taken));

    p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_pc[1:0] == 2'b00) |=> (next_pc[1:0] == 2'b00));
endmodule

bind nxpc_unit nxpc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cur_pc    (cur_pc),
    .insn_word (insn_word),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we),
    .link_reg  (link_reg),
    .link_val  (link_val)
);

// File: tb/tb_nxpc_unit.sv
module tb_nxpc_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] cur_pc;
    logic [31:0] insn_word;
    logic [63:0] opnd_val;
    logic        out_valid;
    logic [63:0] next_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_reg;
    logic [63:0] link_val;
    logic [1:0]  hint;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    nxpc_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
        .insn_word(insn_word), .opnd_val(opnd_val), .out_valid(out_valid),
        .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_reg(link_reg),
        .link_val(link_val), .hint(hint)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] br_w(input logic [5:0] op, input logic [4:0] ra, input logic [20:0] d);
        return {op, ra, d};
    endfunction

    function automatic logic [31:0] jmp_w(input logic [4:0] ra, input logic [4:0] rb, input logic [1:0] h);
        return {6'h1A, ra, rb, h, 14'h0};
    endfunction

    // Condition outcome per R4/R5 from the low three opcode bits
    function automatic bit exp_pass(input logic [2:0] c, input logic [63:0] v);
        case (c)
            3'd0: return v[0] == 1'b0;
            3'd4: return v[0] == 1'b1;
            3'd1: return v == 64'd0;
            3'd5: return v != 64'd0;
            3'd2: return $signed(v) < 0;
            3'd3: return $signed(v) <= 0;
            3'd6: return $signed(v) >= 0;
            default: return $signed(v) > 0;
        endcase
    endfunction

    task automatic step(input logic v, input logic [63:0] pc, input logic [31:0] w, input logic [63:0] op);
        @(negedge clk);
        in_valid  = v;
        cur_pc    = pc;
        insn_word = w;
        opnd_val  = op;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; cur_pc = 64'h40; insn_word = br_w(6'h34, 5'd26, 21'h10);
        opnd_val = '0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 taken", {63'd0, taken}, 64'd0);
        chk("R1 link_we", {63'd0, link_we}, 64'd0);
        chk("R1 next_pc", next_pc, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_seq;
        step(1'b1, 64'h0000_0000_0001_0000, 32'h4000_0401, 64'hFFFF);
        chk("R2 out_valid", {63'd0, out_valid}, 64'd1);
        chk("R2 next_pc", next_pc, 64'h0000_0000_0001_0004);
        chk("R2 taken", {63'd0, taken}, 64'd0);
        chk("R2 link_we", {63'd0, link_we}, 64'd0);
        chk("R2 hint", {62'd0, hint}, 64'd0);
        // 0x31 is not a control opcode
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFC, br_w(6'h31, 5'd3, 21'h40), 64'd0);
        chk("R2 wrap next_pc", next_pc, 64'd0);
        chk("R2 0x31 taken", {63'd0, taken}, 64'd0);
    endtask

    task automatic t_cond;
        logic [63:0] vals [5];
        vals[0] = 64'd0; vals[1] = 64'd1; vals[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        vals[3] = 64'h8000_0000_0000_0000; vals[4] = 64'h7FFF_FFFF_FFFF_FFFE;
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 5; i++) begin
                bit p;
                p = exp_pass(3'(c), vals[i]);
                step(1'b1, 64'h2000, br_w({3'b111, 3'(c)}, 5'd7, 21'h00010), vals[i]);
                chk((c[1:0] == 2'b00) ? "R4 lowbit taken" : "R5 signed taken",
                    {63'd0, taken}, {63'd0, p});
                chk("R3 cond next_pc", next_pc, p ? 64'h2044 : 64'h2004);
                chk("R3 cond no link", {63'd0, link_we}, 64'd0);
            end
        end
    endtask

    task automatic t_disp;
        step(1'b1, 64'h1000, br_w(6'h39, 5'd1, 21'h0F_FFFF), 64'd0);
        chk("R3 max positive disp", next_pc, 64'h0000_0000_0040_1000);
        step(1'b1, 64'h1000, br_w(6'h39, 5'd1, 21'h10_0000), 64'd0);
        chk("R3 max negative disp", next_pc, 64'hFFFF_FFFF_FFC0_1004);
        step(1'b1, 64'h0, br_w(6'h3D, 5'd1, 21'h1F_FFFF), 64'd9);
        chk("R3 disp minus one", next_pc, 64'h0);
    endtask

    task automatic t_uncond;
        step(1'b1, 64'h8000, br_w(6'h30, 5'd9, 21'h1F_FFF0), 64'd0);
        chk("R6 bra taken", {63'd0, taken}, 64'd1);
        chk("R6 bra next_pc", next_pc, 64'h7FC4);
        chk("R6 bra link_reg", {59'd0, link_reg}, 64'd9);
        chk("R6 bra link_val", link_val, 64'h8004);
        chk("R8 bra link_we", {63'd0, link_we}, 64'd1);
        chk("R6 bra hint", {62'd0, hint}, 64'd0);
        step(1'b1, 64'h8000, br_w(6'h34, 5'd26, 21'h00100), 64'd0);
        chk("R6 call next_pc", next_pc, 64'h8404);
        chk("R6 call hint", {62'd0, hint}, 64'd1);
        chk("R6 call link_reg", {59'd0, link_reg}, 64'd26);
    endtask

    task automatic t_jump;
        for (int h = 0; h < 4; h++) begin
            step(1'b1, 64'hA000, jmp_w(5'd26, 5'd27, 2'(h)), 64'h1234_5678_9ABC_DEF3);
            chk("R7 jump next_pc", next_pc, 64'h1234_5678_9ABC_DEF0);
            chk("R7 jump taken", {63'd0, taken}, 64'd1);
            chk("R7 jump link_val", link_val, 64'hA004);
            chk("R7 jump hint", {62'd0, hint}, 64'(h));
            chk("R7 jump link_we", {63'd0, link_we}, 64'd1);
        end
    endtask

    task automatic t_zero_link;
        step(1'b1, 64'h3000, jmp_w(5'd31, 5'd2, 2'b10), 64'h5001);
        chk("R8 jump r31 link_we", {63'd0, link_we}, 64'd0);
        chk("R8 jump r31 next_pc", next_pc, 64'h5000);
        step(1'b1, 64'h3000, br_w(6'h34, 5'd31, 21'h4), 64'd0);
        chk("R8 call r31 link_we", {63'd0, link_we}, 64'd0);
        chk("R8 call r31 taken", {63'd0, taken}, 64'd1);
    endtask

    task automatic t_idle;
        step(1'b0, 64'h6000, br_w(6'h34, 5'd5, 21'h8), 64'd0);
        chk("R9 idle out_valid", {63'd0, out_valid}, 64'd0);
        chk("R9 idle taken", {63'd0, taken}, 64'd0);
        chk("R9 idle link_we", {63'd0, link_we}, 64'd0);
        step(1'b0, 64'h6000, jmp_w(5'd4, 5'd5, 2'b01), 64'h100);
        chk("R9 idle jump link_we", {63'd0, link_we}, 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_seq();
        t_cond();
        t_disp();
        t_uncond();
        t_jump();
        t_zero_link();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule